// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two 32-bit operands and either stores the 64-bit product in a
two-word accumulator or adds the product to it. The accumulator is seen as an upper word
`acc_hi` and a lower word `acc_lo`. There are four operations:

- a signed full-width multiply;
- an unsigned full-width multiply;
- a signed full-width multiply-accumulate;
- a halfword multiply-accumulate, which uses the sign-extended low 16 bits of each operand.

A saturation-enable input changes how both accumulate operations finish. The full-width
accumulate fills or masks the upper half of `acc_hi`. The halfword accumulate clamps the
result to the signed 32-bit range and sets `acc_hi` to 1 to flag that it clamped.

A small controller sequences each operation through three named states:

- `ST_IDLE` → `ST_MULT` when `start` is seen while idle (the operands are latched);
- `ST_MULT` → `ST_ACC` on the next clock, unconditionally (the product register loads);
- `ST_ACC` → `ST_IDLE` on the next clock, unconditionally (the accumulator is written and `done` follows).

While the unit is idle, software-side logic can clear the accumulator or load either word
directly.

Top module: `mac_unit`

## Requirements
- R1: After reset `acc_hi` and `acc_lo` are zero and `busy` and `done` are low.
- R2: Operation code 0 writes the signed 64-bit product of `opnd_a` and `opnd_b`, with the high word in `acc_hi` and the low word in `acc_lo`.
- R3: Operation code 1 writes the unsigned 64-bit product in the same split.
- R4: Operation code 2 with `sat_en` low adds the signed 64-bit product to `{acc_hi,acc_lo}`, wrapping modulo 2^64.
- R5: Operation code 2 with `sat_en` high forces `acc_hi[31:16]` to ones when the 64-bit sum is negative, and otherwise clears `acc_hi[31:15]`. `acc_lo` holds the low word of the sum.
- R6: Operation code 3 with `sat_en` low adds the product of the sign-extended `opnd_a[15:0]` and `opnd_b[15:0]` to `{acc_hi,acc_lo}`, wrapping modulo 2^64.
- R7: Operation code 3 with `sat_en` high gives `acc_hi`=1, `acc_lo`=0x80000000 when the signed sum is below -2^31, and `acc_hi`=1, `acc_lo`=0x7FFFFFFF when it is above 2^31-1. Otherwise it gives the plain sum.
- R8: A `start` accepted at a clock edge raises `busy` for exactly two cycles. The result appears, and `done` pulses for one cycle, on the edge where `busy` falls.
- R9: A `start` that arrives while `busy` is high is ignored: the result does not change, and no second `done` or `busy` period follows.
- R10: `wr_hi` and `wr_lo` load `wr_data` into `acc_hi` and `acc_lo` at the next clock when `busy` is low. They have no effect while `busy` is high.
- R11: `clr` zeroes both words at the next clock when `busy` is low, and wins over a write in the same cycle.
- R12: A write made in the same cycle as an accepted `start` is included in the value that the accumulate adds to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | Operation: 0 signed mul, 1 unsigned mul, 2 full MAC, 3 halfword MAC |
| sat_en | input | 1 | Saturating accumulation enable, latched with `start` |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| clr | input | 1 | Zero the accumulator when idle |
| wr_hi | input | 1 | Load `wr_data` into `acc_hi` when idle |
| wr_lo | input | 1 | Load `wr_data` into `acc_lo` when idle |
| wr_data | input | 32 | Direct write data |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is written |

## Verification
The hardest conditions to reach are the saturation edges, which depend on the accumulator's earlier contents as well as on the operands. These are the halfword sum landing just past ±2^31, and the full-width sum crossing zero with saturation enabled. The bench reaches them by preloading the accumulator through the direct write port with values at and around these limits. From each preload it sweeps every operation, both settings of `sat_en`, and a grid of boundary operands (zero, one, all ones, the most positive and most negative words and halfwords), so that each preload and operand pair lands on or beside a limit. A separate sequence issues `start` and writes during the busy window, to show that they are ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        OP_SMUL  = 2'd0,
        OP_UMUL  = 2'd1,
        OP_MAC32 = 2'd2,
        OP_MAC16 = 2'd3
    } mac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_ACC  = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic accept,
    output logic commit,
    output logic done
);
    ctrl_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_MULT;
            ST_MULT: state_nx = ST_ACC;
            ST_ACC:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_ACC);
        end
    end

    always_comb begin
        busy   = (state != ST_IDLE);
        accept = (state == ST_IDLE) && start;
        commit = (state == ST_ACC);
    end

    // R8
    mult_to_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MULT) |=> (state == ST_ACC));

    // R8
    done_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC) |=> (done && !busy));

    // R9
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state != ST_MULT));
endmodule

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  mac_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int HW = W / 2;

    logic [W:0]       ea_d, eb_d, ea_q, eb_q;
    logic [2*W+1:0]   full;

    always_comb begin
        unique case (op)
            OP_UMUL: begin
                ea_d = {1'b0, a};
                eb_d = {1'b0, b};
            end
            OP_MAC16: begin
                ea_d = {{(HW+1){a[HW-1]}}, a[HW-1:0]};
                eb_d = {{(HW+1){b[HW-1]}}, b[HW-1:0]};
            end
            default: begin
                ea_d = {a[W-1], a};
                eb_d = {b[W-1], b};
            end
        endcase
    end

    assign full = $signed({{(W+1){ea_q[W]}}, ea_q}) * $signed({{(W+1){eb_q[W]}}, eb_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q <= '0;
            eb_q <= '0;
            prod <= '0;
        end else begin
            if (load) begin
                ea_q <= ea_d;
                eb_q <= eb_d;
            end
            prod <= full[2*W-1:0];
        end
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat
    import mac_pkg::*;
#(
    parameter int W = 32
) (
    input  mac_op_e        op,
    input  logic           sat,
    input  logic [2*W-1:0] acc,
    input  logic [2*W-1:0] prod,
    output logic [2*W-1:0] res
);
    localparam int HW = W / 2;
    localparam logic [2*W-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic [2*W-1:0] NEG_LIM = {{(W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic [W-1:0]   FLAG    = W'(1);

    logic [2*W-1:0] sum;
    assign sum = acc + prod;

    always_comb begin
        res = sum;
        unique case (op)
            OP_SMUL, OP_UMUL: res = prod;
            OP_MAC32: begin
                if (sat) begin
                    if (sum[2*W-1]) res[2*W-1 -: HW] = '1;
                    else            res[2*W-1 -: HW+1] = '0;
                end
            end
            OP_MAC16: begin
                if (sat) begin
                    if ($signed(sum) < $signed(NEG_LIM))
                        res = {FLAG, 1'b1, {(W-1){1'b0}}};
                    else if ($signed(sum) > $signed(POS_LIM))
                        res = {FLAG, 1'b0, {(W-1){1'b1}}};
                end
            end
            default: res = sum;
        endcase
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic         sat_en,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         clr,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] acc_hi,
    output logic [W-1:0] acc_lo,
    output logic         busy,
    output logic         done
);
    localparam int HW = W / 2;

    logic           accept, commit;
    mac_op_e        op_in, op_q;
    logic           sat_q;
    logic [2*W-1:0] prod, res;

    assign op_in = mac_op_e'(op);

    mac_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .accept (accept),
        .commit (commit),
        .done   (done)
    );

    mac_mult #(.W(W)) u_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .op    (op_in),
        .a     (opnd_a),
        .b     (opnd_b),
        .prod  (prod)
    );

    mac_sat #(.W(W)) u_sat (
        .op   (op_q),
        .sat  (sat_q),
        .acc  ({acc_hi, acc_lo}),
        .prod (prod),
        .res  (res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_SMUL;
            sat_q <= 1'b0;
        end else if (accept) begin
            op_q  <= op_in;
            sat_q <= sat_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (commit) begin
            acc_hi <= res[2*W-1:W];
            acc_lo <= res[W-1:0];
        end else if (!busy) begin
            if (clr) begin
                acc_hi <= '0;
                acc_lo <= '0;
            end else begin
                if (wr_hi) acc_hi <= wr_data;
                if (wr_lo) acc_lo <= wr_data;
            end
        end
    end

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> ($stable(acc_hi) && $stable(acc_lo)));

    // R5
    mac32_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_q == OP_MAC32 && sat_q) |=>
        ((acc_hi[W-1 -: HW] == '1) || (acc_hi[W-1 -: HW+1] == '0)));

    // R7
    mac16_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_q == OP_MAC16 && sat_q) |=>
        ((acc_hi == {W{acc_lo[W-1]}}) ||
         (acc_hi == W'(1) && (acc_lo == {1'b1, {(W-1){1'b0}}} || acc_lo == {1'b0, {(W-1){1'b1}}}))));

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/tb_mac_unit.sv
`timescale 1ns/1ps
module tb_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        sat_en = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        clr = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] acc_hi, acc_lo;
    logic        busy, done;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mac_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sat_en(sat_en),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .clr(clr), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo), .busy(busy), .done(done)
    );

    task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(logic [1:0] o, logic s, logic [63:0] acc,
                                          logic [31:0] a, logic [31:0] b);
        longint sum;
        longint p;
        case (o)
            2'd0: return longint'($signed(a)) * longint'($signed(b));
            2'd1: return {32'b0, a} * {32'b0, b};
            2'd2: begin
                sum = longint'(acc) + longint'($signed(a)) * longint'($signed(b));
                if (s) begin
                    if (sum < 0) sum[63:48] = '1;
                    else         sum[63:47] = '0;
                end
                return sum;
            end
            default: begin
                p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
                sum = longint'(acc) + p;
                if (s) begin
                    if (sum < -64'sd2147483648) return {32'd1, 32'h8000_0000};
                    if (sum > 64'sd2147483647)  return {32'd1, 32'h7fff_ffff};
                end
                return sum;
            end
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] o, logic s);
        case (o)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return s ? "R5" : "R4";
            default: return s ? "R7" : "R6";
        endcase
    endfunction

    task automatic preload(logic [63:0] v);
        @(negedge clk);
        wr_hi = 1'b1; wr_data = v[63:32];
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[31:0];
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    // start at a negedge, then follow busy/done (R8) and return the result
    task automatic run(logic [1:0] o, logic s, logic [31:0] a, logic [31:0] b,
                       bit check_timing, output logic [63:0] r);
        op = o; sat_en = s; opnd_a = a; opnd_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (check_timing) chk1("R8 busy cycle1", busy, 1'b1);
        @(negedge clk);
        if (check_timing) chk1("R8 busy cycle2", busy, 1'b1);
        @(negedge clk);
        if (check_timing) begin
            chk1("R8 done pulse", done, 1'b1);
            chk1("R8 busy fallen", busy, 1'b0);
        end
        r = {acc_hi, acc_lo};
    endtask

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hffff_ffff, 32'h7fff_ffff,
                              32'h8000_0000, 32'h0000_8000, 32'h0000_7fff, 32'h1234_5678};
    logic [63:0] pre [5] = '{64'h0, 64'h0000_0000_7fff_0000, 64'hffff_ffff_8000_ffff,
                             64'h0000_7fff_ffff_ffff, 64'hffff_8000_0000_0001};

    initial begin
        logic [63:0] r;
        logic [63:0] e;
        repeat (3) @(negedge clk);
        // R1
        chk64("R1 reset acc", {acc_hi, acc_lo}, 64'h0);
        chk1("R1 reset busy", busy, 1'b0);
        chk1("R1 reset done", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 direct writes while idle
        preload(64'hdead_beef_0bad_f00d);
        chk64("R10 write idle", {acc_hi, acc_lo}, 64'hdead_beef_0bad_f00d);

        // R11 clear wins over write
        @(negedge clk);
        clr = 1'b1; wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h5555_aaaa;
        @(negedge clk);
        clr = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
        chk64("R11 clear over write", {acc_hi, acc_lo}, 64'h0);

        // Sweep: R2..R8
        for (int p = 0; p < 5; p++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 2; s++)
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++) begin
                            preload(pre[p]);
                            e = model(o[1:0], s[0], pre[p], vals[i], vals[j]);
                            run(o[1:0], s[0], vals[i], vals[j], (i == j), r);
                            chk64(tag_of(o[1:0], s[0]), r, e);
                        end

        // R7 exact boundaries: sums landing just on and past the limits
        preload(64'h0000_0000_7fff_fffe);
        run(2'd3, 1'b1, 32'h1, 32'h1, 1'b0, r);
        chk64("R7 at +limit", r, 64'h0000_0000_7fff_ffff);
        preload(64'h0000_0000_7fff_ffff);
        run(2'd3, 1'b1, 32'h1, 32'h1, 1'b0, r);
        chk64("R7 past +limit", r, {32'd1, 32'h7fff_ffff});
        preload(64'hffff_ffff_8000_0001);
        run(2'd3, 1'b1, 32'hffff, 32'h1, 1'b0, r);
        chk64("R7 at -limit", r, 64'hffff_ffff_8000_0000);
        preload(64'hffff_ffff_8000_0000);
        run(2'd3, 1'b1, 32'hffff, 32'h1, 1'b0, r);
        chk64("R7 past -limit", r, {32'd1, 32'h8000_0000});
        // R5 sum crossing zero
        preload(64'h0000_0000_0000_0001);
        run(2'd2, 1'b1, 32'hffff_fffe, 32'h1, 1'b0, r);
        chk64("R5 negative fill", r, 64'hffff_ffff_ffff_ffff);

        // R9 / R10: start and writes during busy are ignored
        preload(64'h0);
        op = 2'd2; sat_en = 1'b0; opnd_a = 32'd2; opnd_b = 32'd3; start = 1'b1;
        @(negedge clk);
        op = 2'd0; opnd_a = 32'd100; opnd_b = 32'd100;
        wr_hi = 1'b1; wr_lo = 1'b1; clr = 1'b0; wr_data = 32'h1111_2222;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0; clr = 1'b1;
        @(negedge clk);
        start = 1'b0; clr = 1'b0;
        chk64("R9 R10 result unaffected", {acc_hi, acc_lo}, 64'd6);
        @(negedge clk);
        chk1("R9 no second busy", busy, 1'b0);
        chk1("R9 no second done", done, 1'b0);
        chk64("R9 acc held", {acc_hi, acc_lo}, 64'd6);

        // R12: write in the same cycle as start feeds the accumulate
        @(negedge clk);
        op = 2'd2; sat_en = 1'b0; opnd_a = 32'd4; opnd_b = 32'd5; start = 1'b1;
        wr_lo = 1'b1; wr_data = 32'd1000;
        @(negedge clk);
        start = 1'b0; wr_lo = 1'b0;
        repeat (2) @(negedge clk);
        chk64("R12 same-cycle write", {acc_hi, acc_lo}, 64'd1020);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule